// File: doc/BRIEF.md
# USART Control Word Sequencer

This block is the processor-facing register front end of a programmable serial port. A host reaches it through an active-low chip select, a command/data select, active-low read and write strobes and an 8-bit data bus. Each access takes effect on the first rising clock edge at which the strobe is seen low after having been high while chip select is low. Its results appear after that edge. Every strobe-type output lasts exactly one clock.

After an external reset, or after an internal reset issued by command, control writes are taken in a fixed order. The first control write is the mode word. Synchronous mode then takes one or two sync characters. After that, every control write is a command. The block keeps the mode, sync and command registers and drives the modem control outputs. It forms the status byte and releases each data byte or read request to the shifting cores as a single-clock pulse. The transmitter and receiver cores supply the buffer and error conditions that the status byte reports.

Top module: `usart_ctl_seq`

## Requirements
- R1: With `cs_n` low, a write with `cd`=1 is a control write and a write with `cd`=0 is a data write. A data write pulses `tx_load` for one clock with `tx_byte` equal to the written byte. With `cs_n` high, writes change nothing and `dout_oe` stays 0.
- R2: After external reset, the first control write is stored as `mode_word`. `char_bits` equals 5 plus mode bits [3:2]. `sync_mode` is 1 when mode bits [1:0] are 00.
- R3: When the mode word's bits [1:0] are not 00 (asynchronous), the next control write is a command, and the sync registers are unchanged.
- R4: In synchronous mode, the first sync character follows the mode word. If mode bit 7 is 1, the following control write is a command. If mode bit 7 is 0, a second sync character comes first and is stored in `sync_char2`.
- R5: A command is stored with bit 0 going to `tx_en`, bit 2 to `rx_en`, bit 3 to `brk_en` and bit 7 to `hunt_en`. `dtr_n` is the inverse of bit 1 and `rts_n` is the inverse of bit 5. These outputs change only on a command write.
- R6: A command with bit 6 set pulses `int_rst` for one clock and clears all stored command bits, so `dtr_n`=`rts_n`=1. The next control write is then taken as a mode word.
- R7: Command bit 4 pulses `err_clr` for one clock and is not stored.
- R8: A read with `cd`=1 drives the status byte on `dout` with `dout_oe`=1. The bit order, from bit 7 down to bit 0, is: `~dsr_n`, `sync_brk`, `frm_err`, `ovr_err`, `par_err`, `tx_idle`, RX-ready, TX-ready.
- R9: A read with `cd`=0 drives `rx_byte` on `dout` and pulses `rx_take` for one clock.
- R10: `txrdy_pin` is the TX-ready status bit gated by `tx_en`=1 and `cts_n`=0. The status bit itself does not depend on `cts_n` or `tx_en`.
- R11: TX-ready equals `tx_buf_free`, except that it reads 0 from a data write until `tx_buf_free` has been seen low. RX-ready equals `rx_avail`, except that it reads 0 from a data read until `rx_avail` has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| cd | input | 1 | 1 = control/status, 0 = data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| dout_oe | output | 1 | Read data bus drive enable |
| tx_buf_free | input | 1 | Transmit core can take a byte |
| tx_idle | input | 1 | Transmit core has nothing left to send |
| rx_avail | input | 1 | Receive core holds a byte |
| rx_byte | input | 8 | Byte from the receive core |
| par_err | input | 1 | Parity error flag |
| ovr_err | input | 1 | Overrun error flag |
| frm_err | input | 1 | Framing error flag |
| sync_brk | input | 1 | Sync found or break seen |
| dsr_n | input | 1 | Modem data-set-ready, active low |
| cts_n | input | 1 | Modem clear-to-send, active low |
| dtr_n | output | 1 | Modem terminal-ready, active low |
| rts_n | output | 1 | Modem request-to-send, active low |
| txrdy_pin | output | 1 | Gated transmit-ready indication |
| tx_load | output | 1 | One-clock pulse: byte for transmit core |
| tx_byte | output | 8 | Byte for transmit core |
| rx_take | output | 1 | One-clock pulse: host read the received byte |
| err_clr | output | 1 | One-clock pulse: clear error flags |
| int_rst | output | 1 | One-clock pulse: internal reset |
| mode_word | output | 8 | Stored mode word |
| sync_char1 | output | 8 | First sync character |
| sync_char2 | output | 8 | Second sync character |
| char_bits | output | 4 | Character length in bits |
| sync_mode | output | 1 | Synchronous mode selected |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| brk_en | output | 1 | Send break |
| hunt_en | output | 1 | Sync hunt |

## Verification
The bench targets the points where control-write counting can slip:
- An asynchronous mode word must not wait for sync characters. A design that does would take the first command as a sync byte, and `tx_en` and `dtr_n` would never move.
- A single-sync mode must not swallow the first command as a second sync character.
- An internal reset must restart the sequence. Otherwise the next mode word would land in the command register.

It also checks that the TX-ready status bit is independent of `cts_n` and `tx_en`, while the pin is gated by both. Finally, it checks that a data write or a data read holds its ready bit low until the core's handshake input has dropped. A design that recomputed ready from the input alone would show a stale 1 to the host.

// File: rtl/usart_seq_pkg.sv
package usart_seq_pkg;
  localparam int BW = 8;
  localparam int CHW = 4;

  typedef enum logic [1:0] {S_MODE, S_SYNC1, S_SYNC2, S_CMD} seq_st_t;

  // command bit positions
  localparam int C_TXEN  = 0;
  localparam int C_DTR   = 1;
  localparam int C_RXEN  = 2;
  localparam int C_BRK   = 3;
  localparam int C_ECLR  = 4;
  localparam int C_RTS   = 5;
  localparam int C_IRST  = 6;
  localparam int C_HUNT  = 7;
  localparam logic [BW-1:0] CMD_KEEP = ~((BW'(1) << C_ECLR) | (BW'(1) << C_IRST));

  function automatic logic mode_is_sync(input logic [BW-1:0] m);
    return m[1:0] == 2'b00;
  endfunction

  function automatic logic mode_two_sync(input logic [BW-1:0] m);
    return ~m[7];
  endfunction

  function automatic logic [CHW-1:0] mode_char_bits(input logic [BW-1:0] m);
    return CHW'(5) + CHW'(m[3:2]);
  endfunction
endpackage

// File: rtl/usart_bus_dec.sv
module usart_bus_dec (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic cd,
  input  logic rd_n,
  input  logic wr_n,
  output logic ctl_wr_ev,
  output logic dat_wr_ev,
  output logic dat_rd_ev,
  output logic rd_act
);
  logic wr_q, rd_q;
  logic wr_lead, rd_lead;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  assign wr_lead   = ~cs_n & ~wr_n & wr_q;
  assign rd_lead   = ~cs_n & ~rd_n & rd_q;
  assign ctl_wr_ev = wr_lead & cd;
  assign dat_wr_ev = wr_lead & ~cd;
  assign dat_rd_ev = rd_lead & ~cd;
  assign rd_act    = ~cs_n & ~rd_n;

  // R1: a deselected device sees no access events
  p_cs_gate_r1: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !(ctl_wr_ev || dat_wr_ev || dat_rd_ev));
endmodule

// File: rtl/usart_ctl_fsm.sv
module usart_ctl_fsm
  import usart_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_ev,
  input  logic [BW-1:0] din,
  output logic [BW-1:0] mode_q,
  output logic [BW-1:0] sync1_q,
  output logic [BW-1:0] sync2_q,
  output logic [BW-1:0] cmd_q,
  output logic          err_clr_q,
  output logic          int_rst_q
);
  seq_st_t st;
  logic cmd_ev;

  assign cmd_ev = ctl_ev && (st == S_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_MODE;
      mode_q    <= '0;
      sync1_q   <= '0;
      sync2_q   <= '0;
      cmd_q     <= '0;
      err_clr_q <= 1'b0;
      int_rst_q <= 1'b0;
    end else begin
      err_clr_q <= 1'b0;
      int_rst_q <= 1'b0;
      if (ctl_ev) begin
        unique case (st)
          S_MODE: begin
            mode_q <= din;
            st     <= mode_is_sync(din) ? S_SYNC1 : S_CMD;
          end
          S_SYNC1: begin
            sync1_q <= din;
            st      <= mode_two_sync(mode_q) ? S_SYNC2 : S_CMD;
          end
          S_SYNC2: begin
            sync2_q <= din;
            st      <= S_CMD;
          end
          default: begin
            if (din[C_IRST]) begin
              int_rst_q <= 1'b1;
              cmd_q     <= '0;
              st        <= S_MODE;
            end else begin
              cmd_q     <= din & CMD_KEEP;
              err_clr_q <= din[C_ECLR];
            end
          end
        endcase
      end
    end
  end

  p_async_to_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_ev && st == S_MODE && din[1:0] != 2'b00) |=> st == S_CMD);
  p_single_sync_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_ev && st == S_SYNC1 && mode_q[7]) |=> st == S_CMD);
  p_cmd_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !cmd_ev |=> $stable(cmd_q));
  p_int_reset_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_ev && din[C_IRST]) |=> (st == S_MODE && cmd_q == '0 && int_rst_q));
  p_clr_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    err_clr_q |=> !err_clr_q);
endmodule

// File: rtl/usart_stat.sv
module usart_stat
  import usart_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          dat_wr_ev,
  input  logic          dat_rd_ev,
  input  logic          tx_buf_free,
  input  logic          tx_idle,
  input  logic          rx_avail,
  input  logic          par_err,
  input  logic          ovr_err,
  input  logic          frm_err,
  input  logic          sync_brk,
  input  logic          dsr_n,
  input  logic          cts_n,
  input  logic          tx_en,
  output logic [BW-1:0] status,
  output logic          txrdy_pin
);
  logic tx_hold, rx_hold;
  logic txrdy_s, rxrdy_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hold <= 1'b0;
      rx_hold <= 1'b0;
    end else begin
      if (dat_wr_ev)         tx_hold <= 1'b1;
      else if (!tx_buf_free) tx_hold <= 1'b0;
      if (dat_rd_ev)         rx_hold <= 1'b1;
      else if (!rx_avail)    rx_hold <= 1'b0;
    end
  end

  assign txrdy_s   = tx_buf_free & ~tx_hold;
  assign rxrdy_s   = rx_avail & ~rx_hold;
  assign status    = {~dsr_n, sync_brk, frm_err, ovr_err, par_err, tx_idle, rxrdy_s, txrdy_s};
  assign txrdy_pin = txrdy_s & tx_en & ~cts_n;

  p_tx_clear_r11: assert property (@(posedge clk) disable iff (rst)
    dat_wr_ev |=> !txrdy_s);
  p_rx_clear_r11: assert property (@(posedge clk) disable iff (rst)
    dat_rd_ev |=> !rxrdy_s);
endmodule

// File: rtl/usart_ctl_seq.sv
module usart_ctl_seq
  import usart_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          cd,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [BW-1:0] din,
  output logic [BW-1:0] dout,
  output logic          dout_oe,
  input  logic          tx_buf_free,
  input  logic          tx_idle,
  input  logic          rx_avail,
  input  logic [BW-1:0] rx_byte,
  input  logic          par_err,
  input  logic          ovr_err,
  input  logic          frm_err,
  input  logic          sync_brk,
  input  logic          dsr_n,
  input  logic          cts_n,
  output logic          dtr_n,
  output logic          rts_n,
  output logic          txrdy_pin,
  output logic          tx_load,
  output logic [BW-1:0] tx_byte,
  output logic          rx_take,
  output logic          err_clr,
  output logic          int_rst,
  output logic [BW-1:0] mode_word,
  output logic [BW-1:0] sync_char1,
  output logic [BW-1:0] sync_char2,
  output logic [CHW-1:0] char_bits,
  output logic          sync_mode,
  output logic          tx_en,
  output logic          rx_en,
  output logic          brk_en,
  output logic          hunt_en
);
  logic ctl_wr_ev, dat_wr_ev, dat_rd_ev, rd_act;
  logic [BW-1:0] cmd_q, status;

  usart_bus_dec u_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cd(cd), .rd_n(rd_n), .wr_n(wr_n),
    .ctl_wr_ev(ctl_wr_ev), .dat_wr_ev(dat_wr_ev), .dat_rd_ev(dat_rd_ev), .rd_act(rd_act)
  );

  usart_ctl_fsm u_fsm (
    .clk(clk), .rst(rst), .ctl_ev(ctl_wr_ev), .din(din),
    .mode_q(mode_word), .sync1_q(sync_char1), .sync2_q(sync_char2),
    .cmd_q(cmd_q), .err_clr_q(err_clr), .int_rst_q(int_rst)
  );

  usart_stat u_stat (
    .clk(clk), .rst(rst), .dat_wr_ev(dat_wr_ev), .dat_rd_ev(dat_rd_ev),
    .tx_buf_free(tx_buf_free), .tx_idle(tx_idle), .rx_avail(rx_avail),
    .par_err(par_err), .ovr_err(ovr_err), .frm_err(frm_err), .sync_brk(sync_brk),
    .dsr_n(dsr_n), .cts_n(cts_n), .tx_en(tx_en),
    .status(status), .txrdy_pin(txrdy_pin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_load <= 1'b0;
      tx_byte <= '0;
      rx_take <= 1'b0;
    end else begin
      tx_load <= dat_wr_ev;
      rx_take <= dat_rd_ev;
      if (dat_wr_ev) tx_byte <= din;
    end
  end

  assign dout      = cd ? status : rx_byte;
  assign dout_oe   = rd_act;
  assign char_bits = mode_char_bits(mode_word);
  assign sync_mode = mode_is_sync(mode_word);
  assign tx_en     = cmd_q[C_TXEN];
  assign rx_en     = cmd_q[C_RXEN];
  assign brk_en    = cmd_q[C_BRK];
  assign hunt_en   = cmd_q[C_HUNT];
  assign dtr_n     = ~cmd_q[C_DTR];
  assign rts_n     = ~cmd_q[C_RTS];

  // R10: the pin never claims ready while transmit is disabled or the modem holds off
  p_pin_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (cts_n || !tx_en) |-> !txrdy_pin);
  // R1: a data write hands the byte over on the next clock
  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    dat_wr_ev |=> (tx_load && tx_byte == $past(din)));
endmodule

// File: tb/usart_ctl_seq_tb.sv
module usart_ctl_seq_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cs_n, cd, rd_n, wr_n;
  logic [7:0] din, dout, rx_byte, tx_byte, mode_word, sync_char1, sync_char2;
  logic dout_oe, tx_buf_free, tx_idle, rx_avail, par_err, ovr_err, frm_err, sync_brk;
  logic dsr_n, cts_n, dtr_n, rts_n, txrdy_pin, tx_load, rx_take, err_clr, int_rst;
  logic [3:0] char_bits;
  logic sync_mode, tx_en, rx_en, brk_en, hunt_en;

  usart_ctl_seq u_dut (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic txr, input logic rxr);
    logic [7:0] s;
    s[0] = txr; s[1] = rxr; s[2] = tx_idle; s[3] = par_err;
    s[4] = ovr_err; s[5] = frm_err; s[6] = sync_brk; s[7] = !dsr_n;
    return s;
  endfunction

  function automatic logic [3:0] exp_len(input logic [7:0] m);
    case (m[3:2])
      2'd0: return 4'd5;
      2'd1: return 4'd6;
      2'd2: return 4'd7;
      default: return 4'd8;
    endcase
  endfunction

  task automatic ctl_wr(input logic [7:0] v);
    @(negedge clk); cs_n = 0; cd = 1; din = v; wr_n = 0;
    @(negedge clk); wr_n = 1; cs_n = 1;
  endtask

  task automatic dat_wr(input logic [7:0] v);
    @(negedge clk); cs_n = 0; cd = 0; din = v; wr_n = 0;
    @(negedge clk); wr_n = 1; cs_n = 1;
  endtask

  task automatic rd_stat(output logic [7:0] v);
    @(negedge clk); cs_n = 0; cd = 1; rd_n = 0;
    #1 v = dout;
    @(negedge clk); rd_n = 1; cs_n = 1;
  endtask

  task automatic do_reset();
    rst = 1; cs_n = 1; cd = 0; rd_n = 1; wr_n = 1; din = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    void'($urandom(32'h51A7));
    tx_buf_free = 1; tx_idle = 1; rx_avail = 0; rx_byte = 0;
    par_err = 0; ovr_err = 0; frm_err = 0; sync_brk = 0; dsr_n = 1; cts_n = 1;
    do_reset();

    // reset state
    check("R2 reset mode", mode_word, 8'h00);
    check("R5 reset dtr/rts", {dtr_n, rts_n}, 2'b11);
    check("R5 reset enables", {tx_en, rx_en, brk_en, hunt_en}, 4'h0);
    check("R1 reset bus idle", dout_oe, 1'b0);

    // R2/R3: async mode, then command
    ctl_wr(8'hDE);
    check("R2 mode stored", mode_word, 8'hDE);
    check("R2 char bits", char_bits, exp_len(8'hDE));
    check("R2 async flag", sync_mode, 1'b0);
    ctl_wr(8'h23);
    check("R3 cmd after async mode", {tx_en, dtr_n, rts_n}, 3'b100);
    check("R3 sync untouched", sync_char1, 8'h00);

    // R8: random status patterns
    for (int i = 0; i < 24; i++) begin
      {tx_buf_free, tx_idle, rx_avail, par_err, ovr_err, frm_err, sync_brk, dsr_n} = 8'($urandom);
      rd_stat(s);
      check("R8 status byte", s, exp_status(tx_buf_free, rx_avail));
    end
    tx_buf_free = 1; rx_avail = 0; dsr_n = 1;

    // R10: pin gating vs status bit
    @(negedge clk); cts_n = 0; #1;
    check("R10 pin ready", txrdy_pin, 1'b1);
    @(negedge clk); cts_n = 1; #1;
    check("R10 pin held off", txrdy_pin, 1'b0);
    rd_stat(s);
    check("R10 status ignores cts", s[0], 1'b1);

    // R1/R11: data write
    @(negedge clk); cs_n = 0; cd = 0; din = 8'h5A; wr_n = 0;
    @(negedge clk);
    check("R1 tx_load pulse", tx_load, 1'b1);
    check("R1 tx_byte", tx_byte, 8'h5A);
    wr_n = 1; cs_n = 1;
    @(negedge clk);
    check("R1 tx_load one clock", tx_load, 1'b0);
    rd_stat(s);
    check("R11 txrdy cleared by write", s[0], 1'b0);
    tx_buf_free = 0; @(negedge clk); tx_buf_free = 1;
    rd_stat(s);
    check("R11 txrdy back", s[0], 1'b1);

    // R9/R11: data read
    rx_avail = 1; rx_byte = 8'hC3;
    @(negedge clk); cs_n = 0; cd = 0; rd_n = 0; #1;
    check("R9 data on bus", {dout_oe, dout}, {1'b1, 8'hC3});
    @(negedge clk);
    check("R9 rx_take pulse", rx_take, 1'b1);
    rd_n = 1; cs_n = 1;
    rd_stat(s);
    check("R11 rxrdy cleared by read", s[1], 1'b0);
    rx_avail = 0; @(negedge clk); rx_avail = 1;
    rd_stat(s);
    check("R11 rxrdy back", s[1], 1'b1);
    rx_avail = 0;

    // R1: chip select high ignores access
    @(negedge clk); cs_n = 1; cd = 1; din = 8'h40; wr_n = 0; rd_n = 0; #1;
    check("R1 no drive when deselected", dout_oe, 1'b0);
    @(negedge clk); wr_n = 1; rd_n = 1;
    @(negedge clk);
    check("R1 deselected write ignored", {tx_en, dtr_n, rts_n, int_rst}, 4'b1000);
    cd = 0; wr_n = 0; @(negedge clk); wr_n = 1;
    check("R1 deselected data write", tx_load, 1'b0);

    // R7: error clear pulse
    ctl_wr(8'h33);
    check("R7 err_clr pulse", err_clr, 1'b1);
    @(negedge clk);
    check("R7 err_clr one clock", err_clr, 1'b0);
    check("R7 other bits kept", {tx_en, dtr_n, rts_n}, 3'b100);

    // R6 + R4 two sync chars
    ctl_wr(8'h40);
    check("R6 int_rst pulse", int_rst, 1'b1);
    check("R6 command cleared", {tx_en, dtr_n, rts_n}, 3'b011);
    ctl_wr(8'h0C);
    check("R6 next write is mode", mode_word, 8'h0C);
    check("R2 sync flag", sync_mode, 1'b1);
    ctl_wr(8'h16);
    check("R4 sync1", sync_char1, 8'h16);
    ctl_wr(8'h61);
    check("R4 sync2", sync_char2, 8'h61);
    check("R4 no command yet", {tx_en, rts_n}, 2'b01);
    ctl_wr(8'h85);
    check("R4 command after two sync", {tx_en, rx_en, hunt_en}, 3'b111);

    // R4 single sync
    do_reset();
    ctl_wr(8'h8C);
    ctl_wr(8'h55);
    ctl_wr(8'h04);
    check("R4 single sync stored", sync_char1, 8'h55);
    check("R4 no second sync", sync_char2, 8'h00);
    check("R4 command after one sync", rx_en, 1'b1);

    // R5/R7: random commands
    for (int i = 0; i < 40; i++) begin
      logic [7:0] c;
      c = 8'($urandom) & 8'hBF;
      ctl_wr(c);
      check("R5 command outputs", {tx_en, dtr_n, rx_en, brk_en, rts_n, hunt_en},
            {c[0], !c[1], c[2], c[3], !c[5], c[7]});
      check("R7 err_clr follows bit", err_clr, c[4]);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule